// File: doc/BRIEF.md
# Stepper Motor Phase Sequencer

This block produces the four driver-enable bits of a two-phase bipolar stepping motor (A+, A-, B+, B-) from register-level controls. A mode input, captured once when power-down is released, chooses between two behaviours. In direct phase mode, a 4-bit phase register value goes straight to the outputs. In step mode, an internal 3-bit step index is advanced by software toggling a step-clock register bit, and the outputs are looked up from that index.

In step mode, a control field picks the rotation direction and one of three excitation styles: one phase energised, two phases energised, or half-step alternation. The step-clock bit is synchronised into the block clock and edge-detected, so each 0-to-1 transition advances the index exactly once. While power-down is high, the index is returned to the first state of the selected sequence and every output is forced off. After release the outputs stay off until the first register write strobe or the first step.

Top module: `stepper_phase_seq`

## Requirements
- R1: In direct phase mode (mode captured as 0), once enabled, drv_o equals phase_reg_i for every one of the 16 values, bit 3 = A+, bit 2 = A-, bit 1 = B+, bit 0 = B-.
- R2: In step mode (mode captured as 1) the outputs follow the half-step position p (0..7): A+ on for p in {6,7,0}, A- on for p in {2,3,4}, B+ on for p in {0,1,2}, B- on for p in {4,5,6}. After release with two-phase style and a write strobe, drv_o is 4'b1010.
- R3: The index advances exactly once per 0-to-1 transition of step_clk_i, visible on drv_o within 4 clock edges. A level held at 1 or a 1-to-0 change leaves drv_o unchanged.
- R4: ctrl_dir_i = 0 steps forward (increasing p) and 1 steps in reverse, wrapping modulo 8.
- R5: ctrl_exc_i = 2'b00 is one-phase (odd p, step 2), 2'b01 and 2'b11 are two-phase (even p, step 2), and 2'b10 is half-step (step 1). Two-phase forward gives AB, A'B, A'B', AB'.
- R6: A change of ctrl_exc_i re-maps the index on the next edge. Two-phase rounds p down to an even value. One-phase moves an even p to p-1 modulo 8. Half-step keeps p.
- R7: While pwr_down_i is high, drv_o is 0 in the same cycle, and p is set to the first state of the selected style: 0 for two-phase and half-step, 7 for one-phase.
- R8: mode_i is captured while pwr_down_i is high. Later changes have no effect on drv_o until the next power-down.
- R9: After reset or power-down release, drv_o stays 0 until reg_wr_i or a step. In step mode, A+ and A- are never both on, and neither are B+ and B-.
- R10: While and right after rst_ni is low, drv_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_down_i | input | 1 | Power-down, active high |
| mode_i | input | 1 | 0 direct phase, 1 step mode; captured during power-down |
| reg_wr_i | input | 1 | One-cycle strobe marking a register write |
| phase_reg_i | input | 4 | Direct phase register {A+,A-,B+,B-} |
| step_clk_i | input | 1 | Step-clock register bit, advance on rising transition |
| ctrl_dir_i | input | 1 | 0 forward, 1 reverse |
| ctrl_exc_i | input | 2 | Excitation style |
| drv_o | output | 4 | Driver enables {A+,A-,B+,B-} |

## Verification
A wrong step index shows up directly as a wrong drv_o pattern about three edges after the step-clock bit rises: two synchroniser stages, then the index update. A skipped, doubled or reversed step is therefore visible at the first check after each transition. A wrong re-map shows on the next step after a style change, or immediately when the new style's lookup differs. A wrongly latched mode or enable flag shows as passthrough where a lookup was expected, or as outputs that are live during the off window.

// File: rtl/stp_pkg.sv
package stp_pkg;
  localparam int unsigned DRV_W = 4;
  localparam int unsigned IDX_W = 3;

  typedef enum logic [1:0] {
    EXC_ONE  = 2'b00,
    EXC_TWO  = 2'b01,
    EXC_HALF = 2'b10,
    EXC_TWO2 = 2'b11
  } exc_e;

  // Bring an index onto a legal position of the given style.
  function automatic logic [IDX_W-1:0] remap_idx(input logic [IDX_W-1:0] idx,
                                                 input logic [1:0] exc);
    logic [IDX_W-1:0] r;
    case (exc)
      EXC_ONE:  r = idx[0] ? idx : idx - IDX_W'(1);
      EXC_HALF: r = idx;
      default:  r = {idx[IDX_W-1:1], 1'b0};
    endcase
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] step_size(input logic [1:0] exc);
    return (exc == EXC_HALF) ? IDX_W'(1) : IDX_W'(2);
  endfunction

  // Half-step position to {A+, A-, B+, B-}.
  function automatic logic [DRV_W-1:0] pos_lut(input logic [IDX_W-1:0] idx);
    logic [DRV_W-1:0] d;
    case (idx)
      3'd0: d = 4'b1010;
      3'd1: d = 4'b0010;
      3'd2: d = 4'b0110;
      3'd3: d = 4'b0100;
      3'd4: d = 4'b0101;
      3'd5: d = 4'b0001;
      3'd6: d = 4'b1001;
      default: d = 4'b1000;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/stp_rst_sync.sv
module stp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/stp_edge_det.sv
module stp_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[CHAIN_W-2:0], sig_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rise_o = chain_q[CHAIN_W-2] & ~chain_q[CHAIN_W-1];
endmodule

// File: rtl/stp_index_core.sv
module stp_index_core
  import stp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_down_i,
  input  logic             mode_i,
  input  logic             reg_wr_i,
  input  logic             step_pulse_i,
  input  logic             dir_i,
  input  logic [1:0]       exc_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [1:0]       exc_q_o,
  output logic             mode_o,
  output logic             en_o
);
  logic [IDX_W-1:0] idx_q, idx_d, idx_base;
  logic [1:0]       exc_q, exc_d;
  logic             mode_q, mode_d;
  logic             en_q, en_d;
  logic [IDX_W-1:0] delta;

  always_comb begin
    exc_d    = exc_i;
    idx_base = (exc_i != exc_q) ? remap_idx(idx_q, exc_i) : idx_q;
    delta    = step_size(exc_i);
    idx_d    = idx_base;
    mode_d   = mode_q;
    en_d     = en_q;
    if (pwr_down_i) begin
      idx_d  = remap_idx('0, exc_i);
      mode_d = mode_i;
      en_d   = 1'b0;
    end else begin
      if (step_pulse_i) idx_d = dir_i ? idx_base - delta : idx_base + delta;
      if (step_pulse_i || reg_wr_i) en_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      exc_q  <= EXC_TWO;
      mode_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      exc_q  <= exc_d;
      mode_q <= mode_d;
      en_q   <= en_d;
    end
  end

  assign idx_o   = idx_q;
  assign exc_q_o = exc_q;
  assign mode_o  = mode_q;
  assign en_o    = en_q;
endmodule

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq
  import stp_pkg::*;
#(
  parameter int unsigned RST_STAGES  = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_down_i,
  input  logic             mode_i,
  input  logic             reg_wr_i,
  input  logic [DRV_W-1:0] phase_reg_i,
  input  logic             step_clk_i,
  input  logic             ctrl_dir_i,
  input  logic [1:0]       ctrl_exc_i,
  output logic [DRV_W-1:0] drv_o
);
  logic             rst_n;
  logic             step_pulse;
  logic [IDX_W-1:0] idx;
  logic [1:0]       exc_q;
  logic             mode_q;
  logic             en_q;

  stp_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n)
  );

  stp_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .sig_i (step_clk_i),
    .rise_o(step_pulse)
  );

  stp_index_core u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .pwr_down_i  (pwr_down_i),
    .mode_i      (mode_i),
    .reg_wr_i    (reg_wr_i),
    .step_pulse_i(step_pulse),
    .dir_i       (ctrl_dir_i),
    .exc_i       (ctrl_exc_i),
    .idx_o       (idx),
    .exc_q_o     (exc_q),
    .mode_o      (mode_q),
    .en_o        (en_q)
  );

  always_comb begin
    if (pwr_down_i || !en_q || !rst_n) drv_o = '0;
    else if (mode_q)                   drv_o = pos_lut(idx);
    else                               drv_o = phase_reg_i;
  end
endmodule

// File: rtl/stepper_phase_seq_chk.sv
module stepper_phase_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwr_down_i,
  input logic [3:0] drv_o,
  input logic       mode_q,
  input logic       en_q,
  input logic       step_pulse,
  input logic [2:0] idx,
  input logic [1:0] ctrl_exc_i,
  input logic [1:0] exc_q
);
  // R7
  pd_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_down_i |-> drv_o == 4'b0000);

  // R9
  phase_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q |-> !(drv_o[3] && drv_o[2]) && !(drv_o[1] && drv_o[0]));

  // R9
  off_until_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> drv_o == 4'b0000);

  // R8
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_down_i |=> $stable(mode_q));

  // R3
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_pulse |=> !step_pulse);

  // R3
  idx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_down_i && !step_pulse && ctrl_exc_i == exc_q) |=> $stable(idx));
endmodule

bind stepper_phase_seq stepper_phase_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pwr_down_i(pwr_down_i),
  .drv_o     (drv_o),
  .mode_q    (mode_q),
  .en_q      (en_q),
  .step_pulse(step_pulse),
  .idx       (idx),
  .ctrl_exc_i(ctrl_exc_i),
  .exc_q     (exc_q)
);

// File: tb/stepper_phase_seq_tb_top.sv
module stepper_phase_seq_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pwr_down_i = 1'b0;
  logic       mode_i = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic [3:0] phase_reg_i = 4'h0;
  logic       step_clk_i = 1'b0;
  logic       ctrl_dir_i = 1'b0;
  logic [1:0] ctrl_exc_i = 2'b01;
  logic [3:0] drv_o;

  int checks = 0;
  int errors = 0;
  int p = 0;
  logic [1:0] cur_exc = 2'b01;

  always #10 clk_i = ~clk_i;

  stepper_phase_seq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwr_down_i(pwr_down_i), .mode_i(mode_i),
    .reg_wr_i(reg_wr_i), .phase_reg_i(phase_reg_i), .step_clk_i(step_clk_i),
    .ctrl_dir_i(ctrl_dir_i), .ctrl_exc_i(ctrl_exc_i), .drv_o(drv_o)
  );

  function automatic logic [3:0] exp_drv(input int q);
    logic [3:0] d;
    d[3] = (q == 6) || (q == 7) || (q == 0);
    d[2] = (q >= 2) && (q <= 4);
    d[1] = (q <= 2);
    d[0] = (q >= 4) && (q <= 6);
    return d;
  endfunction

  function automatic int exp_remap(input int q, input logic [1:0] e);
    if (e == 2'b10) return q;
    if (e == 2'b00) return (q % 2 == 1) ? q : (q + 7) % 8;
    return q - (q % 2);
  endfunction

  task automatic check(input string req, input logic [3:0] exp);
    checks++;
    if (drv_o !== exp) begin
      errors++;
      $display("FAIL %s: drv_o=%b expected %b", req, drv_o, exp);
    end
  endtask

  task automatic write_strobe(input logic [3:0] v);
    @(negedge clk_i);
    phase_reg_i = v;
    reg_wr_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic power_cycle(input logic m);
    @(negedge clk_i);
    mode_i = m;
    pwr_down_i = 1'b1;
    @(negedge clk_i);
    check("R7", 4'b0000);
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    pwr_down_i = 1'b0;
    p = exp_remap(0, cur_exc);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check("R9", 4'b0000);
  endtask

  task automatic set_exc(input logic [1:0] e);
    @(negedge clk_i);
    ctrl_exc_i = e;
    @(posedge clk_i);
    @(negedge clk_i);
    if (e != cur_exc) p = exp_remap(p, e);
    cur_exc = e;
  endtask

  task automatic do_step(input string req);
    int sz;
    sz = (cur_exc == 2'b10) ? 1 : 2;
    @(negedge clk_i);
    step_clk_i = 1'b1;
    p = ctrl_dir_i ? (p + 8 - sz) % 8 : (p + sz) % 8;
    repeat (4) @(posedge clk_i);
    @(negedge clk_i);
    check(req, exp_drv(p));
    repeat (5) @(posedge clk_i);
    @(negedge clk_i);
    check("R3", exp_drv(p));
    step_clk_i = 1'b0;
    repeat (5) @(posedge clk_i);
    @(negedge clk_i);
    check("R3", exp_drv(p));
    check("R9", {1'b0, drv_o[2], 1'b0, drv_o[0]} | (drv_o & {~drv_o[2], 1'b1, ~drv_o[0], 1'b1}));
  endtask

  initial begin
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    check("R10", 4'b0000);
    rst_ni = 1'b1;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check("R10", 4'b0000);

    // Direct phase mode sweep
    power_cycle(1'b0);
    for (int v = 0; v < 16; v++) begin
      write_strobe(4'(v));
      check("R1", 4'(v));
    end
    @(negedge clk_i);
    mode_i = 1'b1;
    phase_reg_i = 4'b0101;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    check("R8", 4'b0101);

    // Step mode, two-phase initial state
    cur_exc = 2'b01;
    ctrl_exc_i = 2'b01;
    power_cycle(1'b1);
    write_strobe(4'b1111);
    check("R2", 4'b1010);
    @(negedge clk_i);
    mode_i = 1'b0;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    check("R8", 4'b1010);

    // Sweep styles and directions
    for (int e = 0; e < 4; e++) begin
      for (int d = 0; d < 2; d++) begin
        set_exc(2'(e));
        ctrl_dir_i = d[0];
        check("R6", exp_drv(p));
        for (int s = 0; s < 9; s++) begin
          do_step((d == 0) ? "R4/R5 forward" : "R4/R5 reverse");
        end
      end
    end

    // Re-map from odd half-step position
    set_exc(2'b10);
    ctrl_dir_i = 1'b0;
    if (p % 2 == 0) do_step("R5");
    set_exc(2'b01);
    check("R6", exp_drv(p));
    do_step("R6");
    set_exc(2'b10);
    do_step("R5");
    set_exc(2'b00);
    check("R6", exp_drv(p));

    // Power-down mid-run in one-phase style
    mode_i = 1'b1;
    power_cycle(1'b1);
    write_strobe(4'b0000);
    check("R7", exp_drv(7));
    do_step("R7");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule